// File: doc/BRIEF.md
# Integer-Modulus Sine Oscillator

This block is a numerically controlled oscillator whose phase counter wraps at an arbitrary integer modulus instead of a power of two. On every sample where the enable is high, it adds an integer tuning word to the phase index and wraps the sum at the modulus. The index then addresses a table that holds exactly one sine period, split into as many entries as the modulus. Because the index is the table address with no bits dropped, no phase-truncation spurs appear. The only error left is the rounding of the stored amplitudes. The output frequency is exactly tune·fs/MODULUS.

A typical use is a sample-clock system that needs tones on an exact grid of fs/MODULUS. One example is a 20-entry table at 10 MHz, which gives 500 kHz steps. For an even modulus, the tuning values 1 through MODULUS/2−1 give tones below fs/2. Tuning codes at or above the modulus are folded back into range before they are added.

Top module: `modulus_dds`

## Requirements
- R1: While `rst` is high at a clock edge, `phase` becomes 0 and `sample` becomes 0 at that edge.
- R2: At a clock edge with `en` high and `tune` < MODULUS, `phase` becomes (phase + tune) mod MODULUS.
- R3: At a clock edge with `en` high and `tune` ≥ MODULUS, `phase` becomes (phase + tune − MODULUS) mod MODULUS, which is the same as adding tune mod MODULUS.
- R4: At a clock edge with `en` low, `phase` keeps its value whatever `tune` carries.
- R5: With `en` high and `tune` = 0, `phase` keeps its value and `sample` stays at the table entry for that index.
- R6: `sample` after a clock edge equals the table entry addressed by the `phase` value held just before that edge, so the sample lags its address by one clock.
- R7: Table entry i is round((1 − 2^−(DATA_W−2))·sin(2πi/MODULUS)·2^(DATA_W−1)) in DATA_W-bit two's complement. |sample| never exceeds 2^(DATA_W−1)−2, which is 32766 for DATA_W = 16 at index MODULUS/4.
- R8: `phase` is always below MODULUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable; the phase advances and tune is taken only while high |
| tune | input | $clog2(MODULUS) | Integer tuning word; codes at or above MODULUS are folded by one subtraction |
| phase | output | $clog2(MODULUS) | Current phase index, 0 to MODULUS−1 |
| sample | output | DATA_W | Registered sine sample, two's complement |

## Verification
The bench sweeps every code of the 5-bit tuning word against the default modulus of 20. This includes the codes 20 to 31 that must fold back. A wrap that compared with the wrong bound or did not subtract would show an index of 20 or more, or the wrong next index. Idle cycles with changing tuning words catch a design that advances or latches `tune` without `en`. A zero tuning word catches a counter that drifts anyway. Every sample is compared with a table the bench computes from the sine formula, one clock behind the index. This exposes an off-by-one pipeline, a wrong scale factor, or a peak that wraps to a negative value at index 5. A mid-run reset checks that both outputs clear.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Fixed-point amplitude for table slot idx; evaluated at elaboration only.
  function automatic int sine_entry(input int idx, input int modulus, input int width);
    real shrink;
    real scaled;
    int  mag;
    shrink = 1.0 - (1.0 / (2.0 ** (width - 2)));
    scaled = shrink * $sin(TWO_PI * idx / modulus) * (2.0 ** (width - 1));
    if (scaled >= 0.0) begin
      mag = $rtoi($floor(scaled + 0.5));
      return mag;
    end
    mag = $rtoi($floor(-scaled + 0.5));
    return -mag;
  endfunction

endpackage

// File: rtl/dds_tune_fold.sv
module dds_tune_fold #(
  parameter int MODULUS = 20,
  localparam int PH_W   = $clog2(MODULUS)
) (
  input  logic [PH_W-1:0] tune_raw,
  output logic [PH_W-1:0] tune_fold
);

  localparam logic [PH_W:0] LIM = (PH_W+1)'(MODULUS);

  generate
    if (MODULUS == (1 << PH_W)) begin : g_pow2
      // every code already lies below the modulus
      assign tune_fold = tune_raw;
    end else begin : g_fold
      // 2^PH_W < 2*MODULUS, so a single subtraction reaches tune mod MODULUS
      logic [PH_W:0] wide;
      logic [PH_W:0] less;
      assign wide = {1'b0, tune_raw};
      assign less = wide - LIM;
      assign tune_fold = (wide >= LIM) ? less[PH_W-1:0] : tune_raw;
    end
  endgenerate

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int MODULUS = 20,
  localparam int PH_W   = $clog2(MODULUS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] idx
);

  localparam logic [PH_W:0] LIM = (PH_W+1)'(MODULUS);

  logic [PH_W:0]   sum;
  logic [PH_W:0]   sum_wrapped;
  logic [PH_W-1:0] idx_next;

  always_comb begin
    sum         = {1'b0, idx} + {1'b0, step};
    sum_wrapped = sum - LIM;
    idx_next    = (sum >= LIM) ? sum_wrapped[PH_W-1:0] : sum[PH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (en) begin
      idx <= idx_next;
    end
  end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int MODULUS = 20,
  parameter int DATA_W  = 16,
  localparam int PH_W   = $clog2(MODULUS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PH_W-1:0]          addr,
  output logic signed [DATA_W-1:0] dout
);

  import dds_pkg::*;

  logic signed [DATA_W-1:0] mem [MODULUS];

  initial begin
    for (int i = 0; i < MODULUS; i++) begin
      mem[i] = DATA_W'(sine_entry(i, MODULUS, DATA_W));
    end
  end

  // synchronous read with output register
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else begin
      dout <= mem[addr];
    end
  end

endmodule

// File: rtl/modulus_dds.sv
module modulus_dds #(
  parameter int MODULUS = 20,
  parameter int DATA_W  = 16,
  localparam int PH_W   = $clog2(MODULUS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [PH_W-1:0]          tune,
  output logic [PH_W-1:0]          phase,
  output logic signed [DATA_W-1:0] sample
);

  logic [PH_W-1:0] step;

  dds_tune_fold #(.MODULUS(MODULUS)) u_fold (
    .tune_raw  (tune),
    .tune_fold (step)
  );

  dds_phase_acc #(.MODULUS(MODULUS)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .step (step),
    .idx  (phase)
  );

  dds_sine_rom #(.MODULUS(MODULUS), .DATA_W(DATA_W)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (phase),
    .dout (sample)
  );

endmodule

// File: rtl/modulus_dds_chk.sv
module modulus_dds_chk #(
  parameter int MODULUS = 20,
  parameter int DATA_W  = 16,
  localparam int PH_W   = $clog2(MODULUS)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic [PH_W-1:0]          tune,
  input logic [PH_W-1:0]          phase,
  input logic signed [DATA_W-1:0] sample
);

  localparam int PEAK = (1 << (DATA_W - 1)) - 2;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < MODULUS); // R8

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en && int'(tune) < MODULUS) |=>
      int'(phase) == (int'($past(phase)) + int'($past(tune))) % MODULUS); // R2

  AST_STEP_FOLDED: assert property (@(posedge clk) disable iff (rst)
    (en && int'(tune) >= MODULUS) |=>
      int'(phase) == (int'($past(phase)) + int'($past(tune)) - MODULUS) % MODULUS); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase)); // R4

  AST_ZERO_TUNE: assert property (@(posedge clk) disable iff (rst)
    (en && tune == '0) |=> $stable(phase)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (int'(sample) <= PEAK) && (int'(sample) >= -PEAK)); // R7

endmodule

bind modulus_dds modulus_dds_chk #(.MODULUS(MODULUS), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .tune   (tune),
  .phase  (phase),
  .sample (sample)
);

// File: tb/tb_modulus_dds.sv
`timescale 1ns/1ps
module tb_modulus_dds;

  localparam int L  = 20;
  localparam int DW = 16;
  localparam int PW = $clog2(L);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 en  = 1'b0;
  logic [PW-1:0]        tune = '0;
  logic [PW-1:0]        phase;
  logic signed [DW-1:0] sample;

  int n_cmp  = 0;
  int n_bad  = 0;
  int exp_m  = 0;
  int tbl [L];
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  modulus_dds #(.MODULUS(L), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .en(en), .tune(tune), .phase(phase), .sample(sample)
  );

  function automatic int model_entry(input int i);
    real a;
    a = (1.0 - 1.0 / 16384.0) * $sin(2.0 * 3.141592653589793 * i / L) * 32768.0;
    if (a < 0.0) return -$rtoi($floor(-a + 0.5));
    return $rtoi($floor(a + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // drive at negedge, sample 1 ns after the following rising edge
  task automatic tick(input logic e, input int kv, input string req);
    int prev;
    @(negedge clk);
    en   = e;
    tune = PW'(kv);
    prev = exp_m;
    if (e) exp_m = (exp_m + (kv % L)) % L;
    @(posedge clk);
    #1;
    check(int'(phase) == exp_m, req, int'(phase), exp_m);
    check(int'(sample) == tbl[prev], {req, "/R6"}, int'(sample), tbl[prev]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int maxabs;
    for (int i = 0; i < L; i++) tbl[i] = model_entry(i);

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(phase == '0, "R1", int'(phase), 0);
    check(sample == '0, "R1", int'(sample), 0);
    @(negedge clk);
    rst = 1'b0;
    exp_m = 0;

    // R7: walk every entry with tune = 1, check peak value
    maxabs = 0;
    for (int s = 0; s < L + 2; s++) begin
      tick(1'b1, 1, "R7");
      if (int'(sample) > maxabs) maxabs = int'(sample);
      if (-int'(sample) > maxabs) maxabs = -int'(sample);
    end
    check(tbl[L/4] == 32766, "R7", tbl[L/4], 32766);
    check(maxabs == 32766, "R7", maxabs, 32766);

    // R2 / R3 / R5: every tuning code
    for (int k = 0; k < (1 << PW); k++) begin
      for (int s = 0; s < 23; s++) begin
        if (k == 0)      tick(1'b1, k, "R5");
        else if (k < L)  tick(1'b1, k, "R2");
        else             tick(1'b1, k, "R3");
        check(int'(phase) < L, "R8", int'(phase), L - 1);
      end
    end

    // R4: enable low, tuning word wiggles
    tick(1'b1, 7, "R2");
    for (int s = 0; s < 12; s++) tick(1'b0, (s * 5 + 3) % 32, "R4");

    // R5: explicit hold with constant sample
    for (int s = 0; s < 4; s++) tick(1'b1, 0, "R5");

    // R1: reset mid-run
    tick(1'b1, 3, "R2");
    tick(1'b1, 3, "R2");
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    tune = PW'(9);
    @(posedge clk);
    #1;
    check(phase == '0, "R1", int'(phase), 0);
    check(sample == '0, "R1", int'(sample), 0);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    exp_m = 0;
    tick(1'b1, 9, "R2");
    tick(1'b1, 9, "R2");
    tick(1'b1, 9, "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule